// File: doc/BRIEF.md
# Speculative Reorder Buffer with Commit-Time Flush

This block keeps the instructions of an out-of-order core in program order between issue and retirement. Each issued instruction claims the next free slot of a circular buffer. The slot index goes back to the issue stage as the instruction's rename tag. Results arrive later, in any order, on a result broadcast bus that carries that tag. The matching slot stores the value and becomes ready. Later instructions can read a finished result by tag before it retires.

Retirement takes place only at the oldest slot, and only once that slot is ready. A register-writing instruction drives the register-file write port. A store drives the store port with its address and data. A correctly predicted branch simply leaves the buffer. A mispredicted branch, or any instruction that reported an exception, does not retire normally. Instead the block clears every slot and raises a one-cycle pipeline flush. For a mispredict the flush carries the corrected branch target as the redirect PC. For an exception it carries a fixed handler address and reports the faulting PC on a separate output.

Architectural state is therefore only ever written in program order, so speculation and precise exceptions are handled by the same mechanism.

Top module: `spec_rob`

## Requirements
- R1: `alloc_ok` is high exactly when fewer than DEPTH (8) slots are occupied and no flush is being raised. A request accepted while `alloc_ok` is high claims slot `alloc_tag`, and tags are handed out in increasing order modulo DEPTH. A request made while `alloc_ok` is low is ignored.
- R2: A broadcast with `wb_valid` high and `wb_tag` naming an occupied slot stores `wb_data`, `wb_aux`, `wb_exc` and `wb_mispredict` into that slot and marks it ready.
- R3: A broadcast whose tag names an unoccupied slot changes nothing. A later lookup of that tag, or of the instruction that next claims that slot, reports not ready.
- R4: Only the oldest slot retires, and only when it is ready. If its kind is register (`kind` code 2'b00), `rf_we` is high for that cycle, with `rf_addr` set to its destination and `rf_data` set to its result. As a result, register writes come out in allocation order, whatever order the results arrived in.
- R5: A retiring store (`kind` code 2'b10) drives `st_we` for one cycle, with `st_addr` set to its `wb_aux` value and `st_data` set to its `wb_data` value. It never drives `rf_we`.
- R6: A retiring branch (code 2'b01) without a mispredict, or a no-destination instruction (code 2'b11), leaves the buffer without driving any write port.
- R7: When the oldest slot is ready, is a branch, and carries a mispredict flag, the block raises `flush` with `redirect_pc` equal to that branch's `wb_aux` target and drives neither write port. On the next cycle the buffer is empty and the next tag handed out equals the branch's own slot index.
- R8: When the oldest slot is ready and carries an exception flag, whatever its kind, the block raises `flush` and `exc_valid`, with `redirect_pc` equal to HANDLER (default 32'h0000_0100) and `exc_pc` equal to the slot's PC. The instruction does not retire through a write port. An exception takes priority over a mispredict.
- R9: The lookup port reports `lk_valid` high when slot `lk_tag` is occupied and ready, with `lk_data` holding its result. A broadcast to that occupied slot in the same cycle is forwarded: `lk_valid` is high and `lk_data` equals `wb_data`.
- R10: An allocation and a retirement in the same cycle leave the occupancy unchanged.
- R11: After reset the buffer is empty, `alloc_ok` is high, `alloc_tag` is 0, and `flush`, `exc_valid`, `rf_we` and `st_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Issue stage requests a slot |
| alloc_dest | input | RW | Destination register of the issuing instruction |
| alloc_pc | input | PW | PC of the issuing instruction |
| alloc_kind | input | 2 | 00 register, 01 branch, 10 store, 11 no destination |
| alloc_ok | output | 1 | A slot is free and the request will be accepted |
| alloc_tag | output | TW | Slot index given as the rename tag |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | TW | Tag of the broadcast result |
| wb_data | input | XW | Result value, or store data |
| wb_aux | input | PW | Corrected branch target, or store address |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispredict | input | 1 | Branch was mispredicted |
| lk_tag | input | TW | Operand lookup tag |
| lk_valid | output | 1 | Looked-up slot holds a finished result |
| lk_data | output | XW | Looked-up result |
| rf_we | output | 1 | Register-file write enable at retirement |
| rf_addr | output | RW | Register written |
| rf_data | output | XW | Value written |
| st_we | output | 1 | Store performed at retirement |
| st_addr | output | PW | Store address |
| st_data | output | XW | Store data |
| flush | output | 1 | Discard all speculative work this cycle |
| redirect_pc | output | PW | Fetch restart address while flush is high |
| exc_valid | output | 1 | Flush is caused by an exception |
| exc_pc | output | PW | PC of the faulting instruction |

## Verification
On every cycle, the assertions check the following: the two write ports are never active together, no write port is active during a flush, an exception always comes with a flush, a full buffer refuses allocation, a flush always leaves an empty buffer, and a cycle that both allocates and retires keeps the occupancy. Some behaviour only shows up in the bench's scenarios, where a behavioural model runs in step with the design: out-of-order results retiring in order, the exact redirect target and faulting PC, forwarding on the lookup port, broadcasts to free slots being ignored, and the tag handed out right after a flush.

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int          DEPTH   = 8,
  parameter int          XW      = 32,
  parameter int          RW      = 5,
  parameter int          PW      = 32,
  parameter logic [31:0] HANDLER = 32'h0000_0100,
  localparam int         TW      = $clog2(DEPTH),
  localparam int         CW      = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic [RW-1:0] alloc_dest,
  input  logic [PW-1:0] alloc_pc,
  input  logic [1:0]    alloc_kind,
  output logic          alloc_ok,
  output logic [TW-1:0] alloc_tag,
  input  logic          wb_valid,
  input  logic [TW-1:0] wb_tag,
  input  logic [XW-1:0] wb_data,
  input  logic [PW-1:0] wb_aux,
  input  logic          wb_exc,
  input  logic          wb_mispredict,
  input  logic [TW-1:0] lk_tag,
  output logic          lk_valid,
  output logic [XW-1:0] lk_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_addr,
  output logic [XW-1:0] rf_data,
  output logic          st_we,
  output logic [PW-1:0] st_addr,
  output logic [XW-1:0] st_data,
  output logic          flush,
  output logic [PW-1:0] redirect_pc,
  output logic          exc_valid,
  output logic [PW-1:0] exc_pc
);
  localparam logic [1:0] K_REG = 2'b00, K_BR = 2'b01, K_ST = 2'b10;

  logic [DEPTH-1:0] valid, ready, exc, mis;
  logic [RW-1:0]    dest [DEPTH];
  logic [PW-1:0]    pc   [DEPTH];
  logic [1:0]       kind [DEPTH];
  logic [XW-1:0]    data [DEPTH];
  logic [PW-1:0]    aux  [DEPTH];
  logic [TW-1:0]    head, tail;
  logic [CW-1:0]    count;

  logic retire, alloc_go, wb_hit, lk_fwd;

  assign retire    = valid[head] & ready[head];
  assign flush     = retire & (exc[head] | (kind[head] == K_BR & mis[head]));
  assign exc_valid = retire & exc[head];
  assign exc_pc    = pc[head];
  assign redirect_pc = exc[head] ? HANDLER[PW-1:0] : aux[head];

  assign rf_we   = retire & ~flush & (kind[head] == K_REG);
  assign rf_addr = dest[head];
  assign rf_data = data[head];
  assign st_we   = retire & ~flush & (kind[head] == K_ST);
  assign st_addr = aux[head];
  assign st_data = data[head];

  assign alloc_ok  = (count < CW'(DEPTH)) & ~flush;
  assign alloc_tag = tail;
  assign alloc_go  = alloc_req & alloc_ok;
  assign wb_hit    = wb_valid & valid[wb_tag];

  assign lk_fwd   = wb_hit & (wb_tag == lk_tag);
  assign lk_valid = lk_fwd | (valid[lk_tag] & ready[lk_tag]);
  assign lk_data  = lk_fwd ? wb_data : data[lk_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      valid <= '0;
      tail  <= head;
      count <= '0;
    end else begin
      if (wb_hit) begin
        ready[wb_tag] <= 1'b1;
        data[wb_tag]  <= wb_data;
        aux[wb_tag]   <= wb_aux;
        exc[wb_tag]   <= wb_exc;
        mis[wb_tag]   <= wb_mispredict;
      end
      if (retire) begin
        valid[head] <= 1'b0;
        head        <= head + 1'b1;
      end
      if (alloc_go) begin
        valid[tail] <= 1'b1;
        ready[tail] <= 1'b0;
        exc[tail]   <= 1'b0;
        mis[tail]   <= 1'b0;
        dest[tail]  <= alloc_dest;
        pc[tail]    <= alloc_pc;
        kind[tail]  <= alloc_kind;
        tail        <= tail + 1'b1;
      end
      count <= count + CW'(alloc_go) - CW'(retire);
    end
  end
endmodule

module spec_rob_checks #(
  parameter int DEPTH = 8,
  parameter int PW    = 32,
  parameter logic [31:0] HANDLER = 32'h0000_0100,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_req,
  input logic          alloc_ok,
  input logic          rf_we,
  input logic          st_we,
  input logic          flush,
  input logic          exc_valid,
  input logic [PW-1:0] redirect_pc,
  input logic          retire,
  input logic [CW-1:0] count
);
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && st_we));
  a_r7_no_write_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rf_we && !st_we);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0 && alloc_ok && !flush);
  a_r8_exc_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> flush && redirect_pc == HANDLER[PW-1:0]);
  a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(DEPTH) |-> !alloc_ok);
  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ok && retire && !flush) |=> count == $past(count));
endmodule

bind spec_rob spec_rob_checks #(.DEPTH(DEPTH), .PW(PW), .HANDLER(HANDLER)) u_checks (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
  .rf_we(rf_we), .st_we(st_we), .flush(flush), .exc_valid(exc_valid),
  .redirect_pc(redirect_pc), .retire(retire), .count(count)
);

// File: tb/spec_rob_test.sv
module spec_rob_test;
  localparam int DEPTH = 8, TW = 3, XW = 32, RW = 5, PW = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0100;

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0; logic [RW-1:0] alloc_dest = 0; logic [PW-1:0] alloc_pc = 0;
  logic [1:0] alloc_kind = 0;
  logic wb_valid = 0; logic [TW-1:0] wb_tag = 0; logic [XW-1:0] wb_data = 0;
  logic [PW-1:0] wb_aux = 0; logic wb_exc = 0, wb_mispredict = 0;
  logic [TW-1:0] lk_tag = 0;
  logic alloc_ok, lk_valid, rf_we, st_we, flush, exc_valid;
  logic [TW-1:0] alloc_tag; logic [XW-1:0] lk_data, rf_data, st_data;
  logic [RW-1:0] rf_addr; logic [PW-1:0] st_addr, redirect_pc, exc_pc;

  spec_rob uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int q[$];
  int m_tail = 0;
  bit m_ready[DEPTH], m_exc[DEPTH], m_mis[DEPTH];
  logic [1:0] m_kind[DEPTH]; logic [RW-1:0] m_dest[DEPTH];
  logic [PW-1:0] m_pc[DEPTH], m_aux[DEPTH]; logic [XW-1:0] m_data[DEPTH];
  bit prev_swap = 0;

  function automatic bit inq(int t);
    foreach (q[i]) if (q[i] == t) return 1;
    return 0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    bit hv, hr, fl, ex, rw, sw, aok, lv, fwd; int h; string cl;
    #5;
    hv = q.size() > 0; h = hv ? q[0] : 0; hr = hv && m_ready[h];
    ex = hr && m_exc[h];
    fl = ex || (hr && m_kind[h] == 2'b01 && m_mis[h]);
    rw = hr && !fl && m_kind[h] == 2'b00;
    sw = hr && !fl && m_kind[h] == 2'b10;
    cl = !hr ? "R4" : m_kind[h] == 2'b10 ? "R5" : m_kind[h] == 2'b00 ? "R4" : "R6";
    chk({cl, " rf_we"}, rf_we, rw);
    chk({cl, " st_we"}, st_we, sw);
    if (rw) begin chk("R4 rf_addr", rf_addr, m_dest[h]); chk("R4 rf_data", rf_data, m_data[h]); end
    if (sw) begin chk("R5 st_addr", st_addr, m_aux[h]); chk("R5 st_data", st_data, m_data[h]); end
    chk(ex ? "R8 flush" : "R7 flush", flush, fl);
    chk("R8 exc_valid", exc_valid, ex);
    if (fl) chk(ex ? "R8 redirect" : "R7 redirect", redirect_pc, ex ? HANDLER : m_aux[h]);
    if (ex) chk("R8 exc_pc", exc_pc, m_pc[h]);
    aok = q.size() < DEPTH && !fl;
    chk(prev_swap ? "R10 alloc_ok" : "R1 alloc_ok", alloc_ok, aok);
    if (aok) chk("R1 alloc_tag", alloc_tag, m_tail);
    fwd = wb_valid && wb_tag == lk_tag && inq(lk_tag);
    lv = inq(lk_tag) && (m_ready[lk_tag] || fwd);
    chk(fwd ? "R9 lk_valid" : inq(lk_tag) ? "R2 lk_valid" : "R3 lk_valid", lk_valid, lv);
    if (lv) chk("R9 lk_data", lk_data, fwd ? wb_data : m_data[lk_tag]);
    @(posedge clk);
    prev_swap = 0;
    if (fl) begin
      q.delete(); m_tail = h;
    end else begin
      if (hr) void'(q.pop_front());
      if (wb_valid && inq(wb_tag)) begin
        m_ready[wb_tag] = 1; m_data[wb_tag] = wb_data; m_aux[wb_tag] = wb_aux;
        m_exc[wb_tag] = wb_exc; m_mis[wb_tag] = wb_mispredict;
      end
      if (alloc_req && aok) begin
        q.push_back(m_tail);
        m_ready[m_tail] = 0; m_exc[m_tail] = 0; m_mis[m_tail] = 0;
        m_kind[m_tail] = alloc_kind; m_dest[m_tail] = alloc_dest; m_pc[m_tail] = alloc_pc;
        m_tail = (m_tail + 1) % DEPTH;
        prev_swap = hr;
      end
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    alloc_req = 0; wb_valid = 0; wb_exc = 0; wb_mispredict = 0;
  endtask

  task automatic alloc(input logic [1:0] k, input int d, output int t);
    t = m_tail;
    alloc_req = 1; alloc_kind = k; alloc_dest = RW'(d); alloc_pc = 32'h1000 + 4 * d;
    tick(); quiet();
  endtask

  task automatic wb(input int t, input logic [31:0] d, input logic [31:0] a,
                    input bit e, input bit m);
    wb_valid = 1; wb_tag = TW'(t); wb_data = d; wb_aux = a; wb_exc = e; wb_mispredict = m;
    lk_tag = TW'(t);
    tick(); quiet();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, ta, tb, tx, tmp;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R11 alloc_ok", alloc_ok, 1); chk("R11 alloc_tag", alloc_tag, 0);
    chk("R11 flush", flush, 0); chk("R11 exc_valid", exc_valid, 0);
    chk("R11 rf_we", rf_we, 0); chk("R11 st_we", st_we, 0);
    @(negedge clk);
    tick();
    alloc(2'b00, 1, t0); alloc(2'b00, 2, t1); alloc(2'b10, 3, t2); alloc(2'b01, 4, t3);
    wb(t2, 32'hCAFE, 32'h2000, 0, 0);
    lk_tag = TW'(t2); tick();
    wb(6, 32'hBAD, 0, 0, 0);
    lk_tag = 6; tick();
    wb(t1, 32'h22, 0, 0, 0); wb(t0, 32'h11, 0, 0, 0); wb(t3, 0, 32'h40, 0, 0);
    repeat (5) tick();
    alloc(2'b00, 5, ta); alloc(2'b01, 6, tb);
    for (int i = 0; i < 5; i++) alloc(2'b00, 7 + i, tmp);
    wb(ta, 32'h55, 0, 0, 0);
    alloc(2'b00, 12, tmp);
    alloc(2'b00, 13, tmp);
    alloc(2'b00, 14, tmp);
    wb(tb, 0, 32'h800, 0, 1);
    tick();
    alloc(2'b00, 15, tx);
    chk("R7 tag after flush", tx, tb);
    lk_tag = 6; tick();
    wb(tx, 32'h77, 0, 1, 0);
    tick(); tick();
    for (int c = 0; c < 3000; c++) begin
      int cand[$];
      alloc_req = ($urandom % 3) != 0;
      alloc_kind = 2'($urandom); alloc_dest = RW'($urandom); alloc_pc = $urandom;
      foreach (q[i]) if (!m_ready[q[i]]) cand.push_back(q[i]);
      lk_tag = TW'($urandom);
      if (cand.size() > 0 && ($urandom % 2)) begin
        wb_valid = 1; wb_tag = TW'(cand[$urandom % cand.size()]);
        wb_data = $urandom; wb_aux = $urandom;
        wb_exc = ($urandom % 24) == 0; wb_mispredict = ($urandom % 6) == 0;
        if ($urandom % 2) lk_tag = wb_tag;
      end else if ($urandom % 8 == 0) begin
        wb_valid = 1; wb_tag = TW'($urandom); wb_data = $urandom; wb_aux = $urandom;
        if (inq(wb_tag) && m_ready[wb_tag]) wb_valid = 0;
      end
      tick(); quiet();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule